// File: doc/BRIEF.md
# SCSI Controller Host Register and Command Front-End

This block is the host-side face of a SCSI protocol controller cell. A processor reaches it through an 8-bit register bus. The bus has a 4-bit offset, a write strobe, a read strobe and combinational read data. The block holds the configuration bytes, the clock conversion factor and the selection timeout, and drives them to the rest of the controller. It also keeps two transfer counts. The host writes a 24-bit staging count. A DMA command copies the staging count into a current count, which the host can read back.

Command bytes written to the command offset are decoded at once. Reset-device, reset-bus and DMA-stop act without queueing. All other commands are only acknowledged to the downstream sequencer through a one-cycle strobe that carries the code.

A reset-device command locks the command path until a NOP arrives. The same command preloads the staging count with a build-time chip identifier in its top byte. Software can therefore read the identifier with a short sequence: reset device, enable extended features, issue a DMA NOP, then read the high count byte.

Top module: `sc_host_front`

## Requirements
- R1: After rst_ni the current count reads 0, the config registers read 0, clk_factor_o is 2, sel_timeout_o is 0, and no command strobe is active.
- R2: A write to offset 3 is a command. Bit 7 marks it as a DMA command. Bits 6:0 hold the code: 0 NOP, 1 clear FIFO, 2 reset device, 3 reset bus, 4 DMA stop.
- R3: An accepted reset-bus command pulses bus_reset_o and an accepted DMA-stop command pulses dma_stop_o. Each pulse lasts one cycle and starts in the cycle after the write. Any accepted code other than 0, 2, 3 and 4 pulses cmd_ack_o in that cycle, with cmd_code_o set to bits 6:0 and cmd_dma_o set to bit 7. At most one of the three strobes is high in any cycle.
- R4: An accepted reset-device command sets the staging count to CHIP_ID in bits 23:16 with zeros below it. It also sets the clock factor to 2 and the selection timeout to 0, and leaves the config registers unchanged.
- R5: After a reset-device command, every command with a nonzero code is ignored: it gives no strobe and changes no state. A command with code 0 is accepted and ends the lock.
- R6: An accepted command with code 0 and bit 7 set copies the staging count into the current count. All 24 bits are copied when bit 6 of config 2 is set. Otherwise only bits 15:0 are copied and bits 23:16 become 0. A NOP with bit 7 clear leaves the current count unchanged.
- R7: A read of offset 0xE returns current-count bits 23:16 while bit 6 of config 2 is set, and returns 0 otherwise.
- R8: Writes to offsets 0, 1 and 0xE set staging-count bytes 7:0, 15:8 and 23:16. Reads of offsets 0 and 1 return current-count bytes 7:0 and 15:8.
- R9: Offsets 8, 0xB, 0xC and 0xD hold config 1 to 4 and read back at the same offsets. A write to offset 9 sets clk_factor_o and a write to offset 5 sets sel_timeout_o.
- R10: Reads of offsets 2 to 7, 9, 0xA and 0xF return 0. Writes to offsets 2, 4, 6, 7, 0xA and 0xF change no output and no readable value.
- R11: While rd_i is low, rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid in the cycle rd_i is high |
| clk_factor_o | output | 8 | Clock conversion factor |
| sel_timeout_o | output | 8 | Selection timeout |
| bus_reset_o | output | 1 | One-cycle reset-bus strobe |
| dma_stop_o | output | 1 | One-cycle DMA-stop strobe |
| cmd_ack_o | output | 1 | One-cycle strobe for a command that would be queued |
| cmd_code_o | output | 7 | Code of the last acknowledged command |
| cmd_dma_o | output | 1 | DMA flag of the last acknowledged command |

## Verification
The assertions assume that the bus inputs carry known values while out of reset. They also assume that a read strobe and a write strobe never arrive in the same cycle, so the read mux is never judged against a register changing under it. The bench issues a single operation at a time, each on its own negedge, and releases the strobe before the next one. Random offsets and data cover every offset, including the unmodelled ones. Command bytes are biased toward codes 0 to 6 so that the lock and unlock path runs many times.

// File: rtl/sc_front_pkg.sv
package sc_front_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int CNT_W   = 24;
  localparam int CODE_W  = 7;
  localparam int ENF_BIT = 6;

  localparam logic [ADDR_W-1:0] OFS_CNT_B0 = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CNT_B1 = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_SEL_TO = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_CFG1   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_CLKF   = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_CFG2   = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_CFG3   = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_CFG4   = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_CNT_B2 = 4'hE;

  localparam logic [DATA_W-1:0] CLKF_DEFAULT = 8'd2;

  typedef enum logic [CODE_W-1:0] {
    OP_NOP      = 7'd0,
    OP_FLUSH    = 7'd1,
    OP_DEV_RST  = 7'd2,
    OP_BUS_RST  = 7'd3,
    OP_DMA_STOP = 7'd4
  } op_e;

  function automatic logic [ADDR_W-1:0] cnt_byte_ofs(input int idx);
    case (idx)
      0:       return OFS_CNT_B0;
      1:       return OFS_CNT_B1;
      default: return OFS_CNT_B2;
    endcase
  endfunction
endpackage

// File: rtl/sc_cmd_ctl.sv
module sc_cmd_ctl
  import sc_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic              dev_rst_o,
  output logic              dma_load_o,
  output logic              bus_reset_o,
  output logic              dma_stop_o,
  output logic              ack_o,
  output logic [CODE_W-1:0] ack_code_o,
  output logic              ack_dma_o
);
  logic              blocked_q;
  logic [CODE_W-1:0] code;
  logic              is_nop, accept, queued;

  assign code   = cmd_i[CODE_W-1:0];
  assign is_nop = (code == OP_NOP);
  assign accept = wr_cmd_i && (!blocked_q || is_nop);

  assign dev_rst_o  = accept && (code == OP_DEV_RST);
  assign dma_load_o = accept && is_nop && cmd_i[DATA_W-1];
  assign queued     = accept && !is_nop && (code != OP_DEV_RST) &&
                      (code != OP_BUS_RST) && (code != OP_DMA_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blocked_q   <= 1'b0;
      bus_reset_o <= 1'b0;
      dma_stop_o  <= 1'b0;
      ack_o       <= 1'b0;
      ack_code_o  <= '0;
      ack_dma_o   <= 1'b0;
    end else begin
      if (dev_rst_o)             blocked_q <= 1'b1;
      else if (accept && is_nop) blocked_q <= 1'b0;
      bus_reset_o <= accept && (code == OP_BUS_RST);
      dma_stop_o  <= accept && (code == OP_DMA_STOP);
      ack_o       <= queued;
      if (queued) begin
        ack_code_o <= code;
        ack_dma_o  <= cmd_i[DATA_W-1];
      end
    end
  end

  // R5: locked path gives no strobe
  a_r5_blocked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_q && wr_cmd_i && (cmd_i[CODE_W-1:0] != 7'd0)
    |=> !bus_reset_o && !dma_stop_o && !ack_o);
  a_r5_nop_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i && (cmd_i[CODE_W-1:0] == 7'd0) |=> !blocked_q);
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_reset_o, dma_stop_o, ack_o}));
endmodule

// File: rtl/sc_xfer_cnt.sv
module sc_xfer_cnt
  import sc_front_pkg::*;
#(
  parameter logic [DATA_W-1:0] CHIP_ID = 8'd12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dev_rst_i,
  input  logic              load_i,
  input  logic              enf_i,
  output logic [CNT_W-1:0]  cur_o
);
  localparam int NBYTES = CNT_W / DATA_W;
  localparam int STD_W  = 2 * DATA_W;

  logic [CNT_W-1:0] stage_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_stage
    localparam logic [ADDR_W-1:0] OFS = cnt_byte_ofs(i);
    localparam logic [DATA_W-1:0] RST = (i == NBYTES - 1) ? CHIP_ID : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    stage_q[i*DATA_W +: DATA_W] <= RST;
      else if (dev_rst_i)             stage_q[i*DATA_W +: DATA_W] <= RST;
      else if (wr_i && addr_i == OFS) stage_q[i*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_o <= '0;
    else if (load_i) cur_o <= enf_i ? stage_q
                                    : {{(CNT_W-STD_W){1'b0}}, stage_q[STD_W-1:0]};
  end

  a_r4_id_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> stage_q[CNT_W-1 -: DATA_W] == CHIP_ID);
  a_r6_std_clears_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !enf_i |=> cur_o[CNT_W-1:STD_W] == '0);
  a_r6_hold_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cur_o));
endmodule

// File: rtl/sc_cfg_regs.sv
module sc_cfg_regs
  import sc_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dev_rst_i,
  output logic [DATA_W-1:0] cfg1_o,
  output logic [DATA_W-1:0] cfg2_o,
  output logic [DATA_W-1:0] cfg3_o,
  output logic [DATA_W-1:0] cfg4_o,
  output logic [DATA_W-1:0] clk_factor_o,
  output logic [DATA_W-1:0] sel_to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_o <= '0; cfg2_o <= '0; cfg3_o <= '0; cfg4_o <= '0;
      clk_factor_o <= CLKF_DEFAULT;
      sel_to_o     <= '0;
    end else if (dev_rst_i) begin
      clk_factor_o <= CLKF_DEFAULT;
      sel_to_o     <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_CFG1:   cfg1_o       <= wdata_i;
        OFS_CFG2:   cfg2_o       <= wdata_i;
        OFS_CFG3:   cfg3_o       <= wdata_i;
        OFS_CFG4:   cfg4_o       <= wdata_i;
        OFS_CLKF:   clk_factor_o <= wdata_i;
        OFS_SEL_TO: sel_to_o     <= wdata_i;
        default: ;
      endcase
    end
  end

  a_r4_timing_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> clk_factor_o == CLKF_DEFAULT && sel_to_o == '0);
  a_r4_cfg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> $stable(cfg2_o) && $stable(cfg1_o));
endmodule

// File: rtl/sc_host_front.sv
module sc_host_front
  import sc_front_pkg::*;
#(
  parameter logic [DATA_W-1:0] CHIP_ID = 8'd12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] clk_factor_o,
  output logic [DATA_W-1:0] sel_timeout_o,
  output logic              bus_reset_o,
  output logic              dma_stop_o,
  output logic              cmd_ack_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic              cmd_dma_o
);
  logic              dev_rst, dma_load, wr_cmd;
  logic [CNT_W-1:0]  cur_cnt;
  logic [DATA_W-1:0] cfg1, cfg2, cfg3, cfg4;

  assign wr_cmd = wr_i && (addr_i == OFS_CMD);

  sc_cmd_ctl u_cmd (
    .clk_i, .rst_ni,
    .wr_cmd_i   (wr_cmd),
    .cmd_i      (wdata_i),
    .dev_rst_o  (dev_rst),
    .dma_load_o (dma_load),
    .bus_reset_o,
    .dma_stop_o,
    .ack_o      (cmd_ack_o),
    .ack_code_o (cmd_code_o),
    .ack_dma_o  (cmd_dma_o)
  );

  sc_xfer_cnt #(.CHIP_ID(CHIP_ID)) u_cnt (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .dev_rst_i (dev_rst),
    .load_i    (dma_load),
    .enf_i     (cfg2[ENF_BIT]),
    .cur_o     (cur_cnt)
  );

  sc_cfg_regs u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .dev_rst_i    (dev_rst),
    .cfg1_o       (cfg1),
    .cfg2_o       (cfg2),
    .cfg3_o       (cfg3),
    .cfg4_o       (cfg4),
    .clk_factor_o (clk_factor_o),
    .sel_to_o     (sel_timeout_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        OFS_CNT_B0: rdata_o = cur_cnt[0 +: DATA_W];
        OFS_CNT_B1: rdata_o = cur_cnt[DATA_W +: DATA_W];
        OFS_CNT_B2: rdata_o = cfg2[ENF_BIT] ? cur_cnt[2*DATA_W +: DATA_W] : '0;
        OFS_CFG1:   rdata_o = cfg1;
        OFS_CFG2:   rdata_o = cfg2;
        OFS_CFG3:   rdata_o = cfg3;
        OFS_CFG4:   rdata_o = cfg4;
        default:    rdata_o = '0;
      endcase
    end
  end

  a_r7_hi_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == OFS_CNT_B2 && !cfg2[ENF_BIT] |-> rdata_o == '0);
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (addr_i inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h9, 4'hA, 4'hF})
    |-> rdata_o == '0);
endmodule

// File: tb/sc_host_front_tb.sv
`timescale 1ns/1ps
module sc_host_front_tb;
  localparam logic [7:0] ID = 8'd12;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, clkf, selto;
  logic       wr = 1'b0, rd = 1'b0;
  logic       br, ds, ack, adma;
  logic [6:0] acode;

  int checks = 0, fails = 0;

  // reference model state
  logic [23:0] m_stage, m_cur;
  logic [7:0]  m_cfg1, m_cfg2, m_cfg3, m_cfg4, m_clkf, m_sel;
  logic        m_blk;
  logic [6:0]  m_code;
  logic        m_dma;

  always #2 clk = ~clk;

  sc_host_front #(.CHIP_ID(ID)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .clk_factor_o(clkf), .sel_timeout_o(selto),
    .bus_reset_o(br), .dma_stop_o(ds), .cmd_ack_o(ack),
    .cmd_code_o(acode), .cmd_dma_o(adma)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return m_cur[7:0];
      4'h1: return m_cur[15:8];
      4'h8: return m_cfg1;
      4'hB: return m_cfg2;
      4'hC: return m_cfg3;
      4'hD: return m_cfg4;
      4'hE: return m_cfg2[6] ? m_cur[23:16] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_stage = {ID, 16'h0}; m_cur = '0;
    m_cfg1 = 0; m_cfg2 = 0; m_cfg3 = 0; m_cfg4 = 0;
    m_clkf = 8'd2; m_sel = 0; m_blk = 0; m_code = 0; m_dma = 0;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    logic e_br, e_ds, e_ack, acc;
    logic [6:0] c;
    e_br = 0; e_ds = 0; e_ack = 0;
    c = d[6:0];
    case (a)
      4'h0: m_stage[7:0]   = d;
      4'h1: m_stage[15:8]  = d;
      4'hE: m_stage[23:16] = d;
      4'h5: m_sel  = d;
      4'h8: m_cfg1 = d;
      4'h9: m_clkf = d;
      4'hB: m_cfg2 = d;
      4'hC: m_cfg3 = d;
      4'hD: m_cfg4 = d;
      4'h3: begin
        acc = !m_blk || (c == 0);
        if (acc) begin
          case (c)
            7'd0: begin
              m_blk = 0;
              if (d[7]) m_cur = m_cfg2[6] ? m_stage : {8'h00, m_stage[15:0]};
            end
            7'd2: begin m_blk = 1; m_stage = {ID, 16'h0}; m_clkf = 8'd2; m_sel = 0; end
            7'd3: e_br = 1;
            7'd4: e_ds = 1;
            default: begin e_ack = 1; m_code = c; m_dma = d[7]; end
          endcase
        end
      end
      default: ;
    endcase
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R3 bus_reset strobe", br, e_br);
    chk("R3 dma_stop strobe", ds, e_ds);
    chk("R3 ack strobe", ack, e_ack);
    chk("R3 ack code", {adma, acode}, {m_dma, m_code});
    chk("R9 clk_factor", clkf, m_clkf);
    chk("R9 sel_timeout", selto, m_sel);
  endtask

  task automatic do_rd(input logic [3:0] a, input string req);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 chk(req, rdata, m_read(a));
    rd = 1'b0;
    #0.5 chk("R11 idle read data", rdata, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] a;
    logic [7:0] d;
    void'($urandom(32'd5150));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 clk_factor", clkf, 8'd2);
    chk("R1 sel_timeout", selto, 8'd0);
    chk("R1 strobes", {br, ds, ack}, 3'b000);
    do_rd(4'h0, "R1 count b0");
    do_rd(4'h1, "R1 count b1");
    do_rd(4'hB, "R1 cfg2");

    // R4/R6 identification readout after power-on
    do_wr(4'hB, 8'h40);
    do_wr(4'h3, 8'h80);
    do_rd(4'hE, "R6 ext copy id");
    chk("R4 id in high byte", m_read(4'hE), {24'h0, ID});

    // R6 standard vs extended copy, R8 staging bytes
    do_wr(4'hB, 8'h00);
    do_wr(4'h0, 8'h11); do_wr(4'h1, 8'h22); do_wr(4'hE, 8'h33);
    do_wr(4'h3, 8'h80);
    do_rd(4'h0, "R8 count b0"); do_rd(4'h1, "R8 count b1");
    do_rd(4'hE, "R7 high gated off");
    do_wr(4'hB, 8'h40);
    do_rd(4'hE, "R6 std copy clears top");
    do_wr(4'h3, 8'h80);
    do_rd(4'hE, "R6 ext copy 24 bit");
    do_wr(4'h0, 8'h99);
    do_wr(4'h3, 8'h00);
    do_rd(4'h0, "R6 plain nop no copy");

    // R2/R3 decode
    do_wr(4'h3, 8'h03);
    do_wr(4'h3, 8'h84);
    do_wr(4'h3, 8'h91);
    do_wr(4'h3, 8'h01);

    // R4/R5 reset device and lock
    do_wr(4'h5, 8'h55); do_wr(4'h9, 8'h07); do_wr(4'h8, 8'hA5);
    do_wr(4'h3, 8'h02);
    do_rd(4'h8, "R4 cfg1 kept");
    do_wr(4'h3, 8'h03);
    do_wr(4'h3, 8'h82);
    do_wr(4'h3, 8'h05);
    do_wr(4'h3, 8'h80);
    do_rd(4'hE, "R5 unlock copies id");
    do_wr(4'h3, 8'h04);

    // R10 unmodelled offsets
    do_wr(4'h2, 8'hFF); do_wr(4'h4, 8'hFF); do_wr(4'h6, 8'hFF);
    do_wr(4'h7, 8'hFF); do_wr(4'hA, 8'hFF); do_wr(4'hF, 8'hFF);
    do_rd(4'h3, "R10 read cmd ofs"); do_rd(4'h5, "R10 read sel ofs");
    do_rd(4'h9, "R10 read clkf ofs"); do_rd(4'h0, "R10 count unchanged");

    // random mix
    for (int i = 0; i < 600; i++) begin
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom_range(0, 255));
      if (a == 4'h3 && $urandom_range(0, 3) != 0)
        d = {d[7], 4'h0, 3'($urandom_range(0, 6))};
      do_wr(a, d);
      if ($urandom_range(0, 1) == 1)
        do_rd(4'($urandom_range(0, 15)), "R8 R9 R10 random read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule